// File: doc/BRIEF.md
# Grouped Interrupt Combiner

This block takes a wide bank of level-sensitive interrupt lines and folds them into a smaller set of group requests. The sources are arranged in groups of eight. Each group drives one level output, which is high while at least one of its sources is both pending and enabled. A downstream interrupt controller then needs only one line per group. Software reads the combiner's status to find which source inside the group is asking.

Software reaches the block through a small synchronous register port. The map is organised in 16-byte blocks. Each block serves four consecutive groups, and every group owns one byte lane in each word of its block. Within a block there are four words: one to set enables, one to clear enables, one raw status word and one masked status word. Above the blocks sits a read-only summary that gives one bit per group output.

A build-time option turns the block into a reduced variant. In that variant the group slots at or above a configured limit are never fed: their sources stay idle whatever their inputs do.

Top module: `irq_combiner`

## Requirements
- R1: Source input n belongs to group n/8 and occupies bit n%8 of that group's 8-bit pending and enable vectors.
- R2: A source's pending bit tracks its input level with one clock of latency. It goes high while the input is high and low when the input is low, with no edge capture.
- R3: Group output g is high exactly when the bitwise AND of group g's pending vector and its enable vector is nonzero.
- R4: Address bits [7:4] select block q, which covers groups 4q to 4q+3. Bits [3:2] select the word inside the block. Group 4q+k uses bits 8k+7:8k of each word.
- R5: Word 0 of a block is set-style: each 1 written ORs into the matching enable bit. Word 1 is clear-style: each 1 written clears the matching enable bit. Zeros written to either word change nothing, and reads of either word return 0.
- R6: Reading word 2 of a block returns the four groups' raw pending bits. Reading word 3 returns the pending bits ANDed with the enable bits.
- R7: Byte offset 0x100 reads as one bit per group for groups 0 to 31 (bit g = output of group g). Offset 0x104 does the same for groups 32 to 63 (bit g-32). Neither offset can be written.
- R8: A write to word 2 or word 3 of a block, or to the summary area, is illegal: reg_err is high in the following cycle and no enable bit changes. Any access at or above offset 0x108 is also illegal and reads 0.
- R9: Reset clears every enable and pending bit, so all group outputs and both summary words read 0 after reset, even while inputs stay high.
- R10: With EXT_MODE set, groups at or above EXT_GROUP_LIMIT ignore their inputs. Their pending bits stay 0 and their outputs stay low.
- R11: Group outputs and summary bits change in the cycle after an input change or an enable write. Read data and reg_err are registered and appear in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_GROUPS*8 | Level interrupt sources, bit n is source n |
| reg_valid | input | 1 | Register access request this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read |
| reg_err | output | 1 | Illegal access flag, the cycle after the request |
| grp_out | output | NUM_GROUPS | Per-group combined interrupt level |

## Verification
The combining path is driven by a table of block, source-pattern, set-mask and clear-mask vectors. The vectors cover sources that are pending but fully masked, enabled but idle, a single lane live, all four lanes live, and a clear that removes one bit from a full set. Together they separate raw status from masked status and show the effect of byte-lane placement. Directed cases then cover the rest. One source is toggled on its own to pin down the index mapping, the level tracking and the one-cycle latency. Zero-valued enable writes are applied with a source live. Illegal writes are checked for leaving the outputs untouched. A reset in the middle of a run is applied with inputs still high. A reduced-variant instance runs beside the main one to show groups above the limit staying silent while a group just below the limit still responds.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
  localparam int SRC_W        = 8;
  localparam int GRP_PER_QUAD = 4;
  localparam int WORD_W       = SRC_W * GRP_PER_QUAD;

  typedef enum logic [1:0] {
    WORD_SET = 2'd0,
    WORD_CLR = 2'd1,
    WORD_RAW = 2'd2,
    WORD_MSK = 2'd3
  } word_e;

  // word selector inside a 16-byte block
  function automatic word_e word_of(input logic [3:0] low_addr);
    return word_e'(low_addr[3:2]);
  endfunction

  // next enable vector for one group given set and clear bytes
  function automatic logic [SRC_W-1:0] next_mask(input logic [SRC_W-1:0] cur,
                                                  input logic [SRC_W-1:0] set_b,
                                                  input logic [SRC_W-1:0] clr_b);
    return (cur | set_b) & ~clr_b;
  endfunction

  // group request level
  function automatic logic group_level(input logic [SRC_W-1:0] pend,
                                       input logic [SRC_W-1:0] mask);
    return |(pend & mask);
  endfunction
endpackage

// File: rtl/irqc_group.sv
`timescale 1ns/1ps
module irqc_group
  import irqc_pkg::*;
#(
  parameter bit ACCEPT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] src,
  input  logic [SRC_W-1:0] set_bits,
  input  logic [SRC_W-1:0] clr_bits,
  output logic [SRC_W-1:0] pend,
  output logic [SRC_W-1:0] mask,
  output logic             active
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= '0;
    else        mask <= next_mask(mask, set_bits, clr_bits);
  end

  generate
    if (ACCEPT) begin : g_live
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend <= '0;
        else        pend <= src;
      end
    end else begin : g_dead
      logic [SRC_W-1:0] unused_src;
      assign unused_src = src;
      assign pend = '0;
    end
  endgenerate

  assign active = group_level(pend, mask);
endmodule

// File: rtl/irqc_regif.sv
`timescale 1ns/1ps
module irqc_regif
  import irqc_pkg::*;
#(
  parameter int NUM_GROUPS = 64,
  parameter int ADDR_W     = 9
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        valid,
  input  logic                        write,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [WORD_W-1:0]           wdata,
  input  logic [NUM_GROUPS*SRC_W-1:0] pend_flat,
  input  logic [NUM_GROUPS*SRC_W-1:0] mask_flat,
  input  logic [NUM_GROUPS-1:0]       active,
  output logic [NUM_GROUPS*SRC_W-1:0] set_flat,
  output logic [NUM_GROUPS*SRC_W-1:0] clr_flat,
  output logic                        acc_illegal,
  output logic [WORD_W-1:0]           rdata,
  output logic                        err
);
  localparam int NUM_QUADS  = NUM_GROUPS / GRP_PER_QUAD;
  localparam int QW         = $clog2(NUM_QUADS);
  localparam int SUM_BASE   = NUM_QUADS * 16;
  localparam int SUM_WORDS  = NUM_GROUPS / WORD_W;
  localparam int REGION_END = SUM_BASE + SUM_WORDS * 4;

  logic          in_quads, in_sum, wr_set, wr_clr;
  logic [QW-1:0] q_idx;
  word_e         word;
  int            q_int, s_int;
  logic [WORD_W-1:0] rd_word;
  logic [WORD_W-1:0] quad_pend, quad_mask;

  assign in_quads = addr < ADDR_W'(SUM_BASE);
  assign in_sum   = !in_quads && (addr < ADDR_W'(REGION_END));
  assign q_idx    = addr[QW+3:4];
  assign word     = word_of(addr[3:0]);
  assign q_int    = int'(q_idx);
  assign s_int    = int'(addr[ADDR_W-1:2]) - SUM_BASE / 4;

  assign wr_set = valid && write && in_quads && (word == WORD_SET);
  assign wr_clr = valid && write && in_quads && (word == WORD_CLR);

  assign acc_illegal = valid && ((!in_quads && !in_sum) ||
                       (write && !(in_quads && (word == WORD_SET || word == WORD_CLR))));

  genvar g;
  generate
    for (g = 0; g < NUM_GROUPS; g++) begin : g_lane
      localparam int LANE = g % GRP_PER_QUAD;
      assign set_flat[g*SRC_W +: SRC_W] = (wr_set && q_idx == QW'(g / GRP_PER_QUAD)) ?
                                          wdata[LANE*SRC_W +: SRC_W] : '0;
      assign clr_flat[g*SRC_W +: SRC_W] = (wr_clr && q_idx == QW'(g / GRP_PER_QUAD)) ?
                                          wdata[LANE*SRC_W +: SRC_W] : '0;
    end
  endgenerate

  assign quad_pend = pend_flat[q_int*WORD_W +: WORD_W];
  assign quad_mask = mask_flat[q_int*WORD_W +: WORD_W];

  always_comb begin
    rd_word = '0;
    if (in_quads) begin
      case (word)
        WORD_RAW: rd_word = quad_pend;
        WORD_MSK: rd_word = quad_pend & quad_mask;
        default:  rd_word = '0;
      endcase
    end else if (in_sum && s_int >= 0 && s_int < SUM_WORDS) begin
      rd_word = active[s_int*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      rdata <= (valid && !write && !acc_illegal) ? rd_word : '0;
      err   <= acc_illegal;
    end
  end
endmodule

// File: rtl/irq_combiner.sv
`timescale 1ns/1ps
module irq_combiner
  import irqc_pkg::*;
#(
  parameter int NUM_GROUPS      = 64,
  parameter int ADDR_W          = 9,
  parameter bit EXT_MODE        = 1'b0,
  parameter int EXT_GROUP_LIMIT = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_GROUPS*SRC_W-1:0] irq_in,
  input  logic                        reg_valid,
  input  logic                        reg_write,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [WORD_W-1:0]           reg_wdata,
  output logic [WORD_W-1:0]           reg_rdata,
  output logic                        reg_err,
  output logic [NUM_GROUPS-1:0]       grp_out
);
  localparam int NBITS = NUM_GROUPS * SRC_W;

  logic [NBITS-1:0] pend_flat, mask_flat, set_flat, clr_flat;
  logic             acc_illegal;

  genvar g;
  generate
    for (g = 0; g < NUM_GROUPS; g++) begin : g_grp
      localparam bit ACC = !EXT_MODE || (g < EXT_GROUP_LIMIT);
      irqc_group #(.ACCEPT(ACC)) u_grp (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (irq_in[g*SRC_W +: SRC_W]),
        .set_bits (set_flat[g*SRC_W +: SRC_W]),
        .clr_bits (clr_flat[g*SRC_W +: SRC_W]),
        .pend     (pend_flat[g*SRC_W +: SRC_W]),
        .mask     (mask_flat[g*SRC_W +: SRC_W]),
        .active   (grp_out[g])
      );
    end
  endgenerate

  irqc_regif #(.NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W)) u_regif (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid       (reg_valid),
    .write       (reg_write),
    .addr        (reg_addr),
    .wdata       (reg_wdata),
    .pend_flat   (pend_flat),
    .mask_flat   (mask_flat),
    .active      (grp_out),
    .set_flat    (set_flat),
    .clr_flat    (clr_flat),
    .acc_illegal (acc_illegal),
    .rdata       (reg_rdata),
    .err         (reg_err)
  );
endmodule

// File: rtl/irqc_chk.sv
`timescale 1ns/1ps
module irqc_chk
  import irqc_pkg::*;
#(
  parameter int NUM_GROUPS      = 64,
  parameter int ADDR_W          = 9,
  parameter bit EXT_MODE        = 1'b0,
  parameter int EXT_GROUP_LIMIT = 64
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NUM_GROUPS*SRC_W-1:0] irq_in,
  input logic                        reg_valid,
  input logic                        reg_write,
  input logic [ADDR_W-1:0]           reg_addr,
  input logic [WORD_W-1:0]           reg_wdata,
  input logic [WORD_W-1:0]           reg_rdata,
  input logic                        reg_err,
  input logic [NUM_GROUPS-1:0]       grp_out,
  input logic [NUM_GROUPS*SRC_W-1:0] pend_flat,
  input logic [NUM_GROUPS*SRC_W-1:0] mask_flat,
  input logic                        acc_illegal
);
  localparam int NUM_QUADS = NUM_GROUPS / GRP_PER_QUAD;
  localparam int QW        = $clog2(NUM_QUADS);
  localparam int SUM_BASE  = NUM_QUADS * 16;

  function automatic logic [NUM_GROUPS*SRC_W-1:0] accept_vec();
    logic [NUM_GROUPS*SRC_W-1:0] v = '0;
    for (int i = 0; i < NUM_GROUPS; i++)
      if (!EXT_MODE || i < EXT_GROUP_LIMIT) v[i*SRC_W +: SRC_W] = '1;
    return v;
  endfunction

  localparam logic [NUM_GROUPS*SRC_W-1:0] ACC_V = accept_vec();

  logic [QW-1:0] last_q;
  logic [3:0]    quad_now;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= '0;
    else        last_q <= reg_addr[QW+3:4];
  end
  assign quad_now = grp_out[int'(last_q)*GRP_PER_QUAD +: GRP_PER_QUAD];

  logic clr_all_wr;
  assign clr_all_wr = reg_valid && reg_write && (reg_addr < ADDR_W'(SUM_BASE)) &&
                      (reg_addr[3:2] == 2'd1) && (reg_wdata == '1);

  // R9
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (grp_out == '0 && mask_flat == '0));

  // R2
  pend_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pend_flat == ($past(irq_in) & ACC_V)));

  // R8
  illegal_keeps_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && reg_write && acc_illegal) |=> $stable(mask_flat));

  // R8
  illegal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_illegal |=> reg_err);

  // R7
  summary_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && !reg_write && reg_addr == ADDR_W'(SUM_BASE)) |=>
      (reg_rdata == $past(grp_out[WORD_W-1:0])));

  // R5
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all_wr |=> (quad_now == 4'h0));

  // R10
  ext_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> ((pend_flat & ~ACC_V) == '0));
endmodule

bind irq_combiner irqc_chk #(
  .NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W),
  .EXT_MODE(EXT_MODE), .EXT_GROUP_LIMIT(EXT_GROUP_LIMIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_valid(reg_valid),
  .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .reg_err(reg_err), .grp_out(grp_out),
  .pend_flat(pend_flat), .mask_flat(mask_flat), .acc_illegal(acc_illegal)
);

// File: tb/irq_combiner_tb.sv
`timescale 1ns/1ps
module irq_combiner_tb;
  localparam int NG = 64;
  localparam int NB = NG * 8;
  localparam int LIM = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NB-1:0] irq_in = '0;
  logic reg_valid = 1'b0, reg_write = 1'b0;
  logic [8:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rdata_m, rdata_e;
  logic err_m, err_e;
  logic [NG-1:0] out_m, out_e;

  int errors = 0, checks = 0;
  bit done = 1'b0;
  logic [7:0] mask_m [NG];

  always #10 clk = ~clk;

  irq_combiner u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_valid(reg_valid),
    .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata_m), .reg_err(err_m), .grp_out(out_m));

  irq_combiner #(.EXT_MODE(1'b1), .EXT_GROUP_LIMIT(LIM)) u_ext (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_valid(reg_valid),
    .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata_e), .reg_err(err_e), .grp_out(out_e));

  // block, source pattern, set word, clear word
  typedef struct packed {
    logic [3:0]  quad;
    logic [31:0] pat;
    logic [31:0] setw;
    logic [31:0] clrw;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{4'd0,  32'h000000FF, 32'h00000001, 32'h00000000},
    '{4'd0,  32'h80402010, 32'hFFFFFFFF, 32'h0F0F0F0F},
    '{4'd15, 32'h01020408, 32'h0F0F0F0F, 32'h00000000},
    '{4'd7,  32'hAA55AA55, 32'h55AA55AA, 32'h00000000},
    '{4'd8,  32'h00FF0000, 32'h00FF00FF, 32'h00010000},
    '{4'd3,  32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one bus access; read data and error captured the cycle after
  task automatic bus(input bit w, input logic [8:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output logic er);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = w; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
    rd = rdata_m; er = err_m;
    if (w && a < 9'h100 && a[3:2] < 2'd2)
      for (int k = 0; k < 4; k++) begin
        if (a[3:2] == 2'd0) mask_m[a[7:4]*4+k] = mask_m[a[7:4]*4+k] | d[k*8 +: 8];
        else                mask_m[a[7:4]*4+k] = mask_m[a[7:4]*4+k] & ~d[k*8 +: 8];
      end
  endtask

  function automatic logic [NG-1:0] model_out(input bit ext);
    logic [NG-1:0] o;
    for (int g = 0; g < NG; g++)
      o[g] = (|(irq_in[g*8 +: 8] & mask_m[g])) && (!ext || g < LIM);
    return o;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int g = 0; g < NG; g++) mask_m[g] = 8'h00;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic er;
    logic [31:0] mw;
    for (int g = 0; g < NG; g++) mask_m[g] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    check("R9 outputs after reset", 64'(out_m), 64'h0);
    bus(1'b0, 9'h100, 32'h0, rd, er);
    check("R9 summary low after reset", 64'(rd), 64'h0);
    check("R9 no error on legal read", 64'(er), 64'h0);
    bus(1'b0, 9'h104, 32'h0, rd, er);
    check("R9 summary high after reset", 64'(rd), 64'h0);

    // table of combining vectors: R3 R4 R5 R6 R7
    for (int i = 0; i < 6; i++) begin
      irq_in = '0;
      bus(1'b1, {1'b0, VECS[i].quad, 4'h4}, 32'hFFFFFFFF, rd, er);
      bus(1'b1, {1'b0, VECS[i].quad, 4'h0}, VECS[i].setw, rd, er);
      bus(1'b1, {1'b0, VECS[i].quad, 4'h4}, VECS[i].clrw, rd, er);
      @(negedge clk);
      irq_in[VECS[i].quad*32 +: 32] = VECS[i].pat;
      @(negedge clk);
      check($sformatf("R3 outputs vec%0d", i), 64'(out_m), 64'(model_out(1'b0)));
      bus(1'b0, {1'b0, VECS[i].quad, 4'h8}, 32'h0, rd, er);
      check($sformatf("R6 raw word vec%0d", i), 64'(rd), 64'(VECS[i].pat));
      mw = {mask_m[VECS[i].quad*4+3], mask_m[VECS[i].quad*4+2],
            mask_m[VECS[i].quad*4+1], mask_m[VECS[i].quad*4]};
      check($sformatf("R4 enable model vec%0d", i), 64'(mw), 64'(VECS[i].setw & ~VECS[i].clrw));
      bus(1'b0, {1'b0, VECS[i].quad, 4'hC}, 32'h0, rd, er);
      check($sformatf("R6 masked word vec%0d", i), 64'(rd), 64'(VECS[i].pat & mw));
      bus(1'b0, (VECS[i].quad < 8) ? 9'h100 : 9'h104, 32'h0, rd, er);
      check($sformatf("R7 summary vec%0d", i), 64'(rd),
            64'((VECS[i].quad < 8) ? model_out(1'b0)[31:0] : model_out(1'b0)[63:32]));
      bus(1'b0, {1'b0, VECS[i].quad, 4'h0}, 32'h0, rd, er);
      check($sformatf("R5 set word reads zero vec%0d", i), 64'(rd), 64'h0);
      bus(1'b0, {1'b0, VECS[i].quad, 4'h4}, 32'h0, rd, er);
      check($sformatf("R5 clear word reads zero vec%0d", i), 64'(rd), 64'h0);
    end

    // R1 R2 R11 single source: input 43 is group 5 bit 3
    irq_in = '0;
    bus(1'b1, 9'h010, 32'h0000FF00, rd, er);
    @(negedge clk);
    irq_in[43] = 1'b1;
    #1;
    check("R11 output not yet changed", 64'(out_m[5]), 64'h0);
    @(negedge clk);
    check("R11 output one cycle after input", 64'(out_m[5]), 64'h1);
    check("R1 only group 5 active", 64'(out_m), 64'h20);
    bus(1'b0, 9'h018, 32'h0, rd, er);
    check("R1 source 43 at lane1 bit3", 64'(rd), 64'h00000800);

    // R5 zero writes change nothing
    bus(1'b1, 9'h014, 32'h00000000, rd, er);
    bus(1'b1, 9'h010, 32'h00000000, rd, er);
    check("R5 zero clear keeps output", 64'(out_m[5]), 64'h1);

    // R8 illegal writes
    bus(1'b1, 9'h01C, 32'hFFFFFFFF, rd, er);
    check("R8 write to masked word flags error", 64'(er), 64'h1);
    bus(1'b1, 9'h018, 32'hFFFFFFFF, rd, er);
    check("R8 write to raw word flags error", 64'(er), 64'h1);
    bus(1'b1, 9'h100, 32'hFFFFFFFF, rd, er);
    check("R8 write to summary flags error", 64'(er), 64'h1);
    check("R8 illegal writes keep output", 64'(out_m), 64'h20);
    bus(1'b0, 9'h01C, 32'h0, rd, er);
    check("R8 illegal writes keep enables", 64'(rd), 64'h00000800);
    bus(1'b0, 9'h108, 32'h0, rd, er);
    check("R8 read past region flags error", 64'(er), 64'h1);
    check("R8 read past region returns zero", 64'(rd), 64'h0);

    // R2 level tracking: drop the input
    @(negedge clk);
    irq_in[43] = 1'b0;
    @(negedge clk);
    check("R2 output follows input low", 64'(out_m[5]), 64'h0);

    // R10 reduced variant: groups 15 and 17 with every enable set
    bus(1'b1, 9'h030, 32'hFFFFFFFF, rd, er);
    bus(1'b1, 9'h040, 32'hFFFFFFFF, rd, er);
    @(negedge clk);
    irq_in[15*8+2] = 1'b1;
    irq_in[17*8+6] = 1'b1;
    @(negedge clk);
    check("R10 group below limit responds", 64'(out_e[15]), 64'h1);
    check("R10 group above limit stays low", 64'(out_e[17]), 64'h0);
    check("R10 full variant group 17 high", 64'(out_m[17]), 64'h1);
    bus(1'b0, 9'h048, 32'h0, rd, er);
    check("R10 reduced raw word above limit", 64'(rdata_e), 64'h0);
    check("R10 full raw word", 64'(rd), 64'h00004000);

    // R9 reset in mid run with inputs high
    do_reset();
    #1;
    check("R9 mid-run reset clears outputs", 64'(out_m), 64'h0);
    repeat (2) @(negedge clk);
    check("R9 enables cleared, outputs low", 64'(out_m), 64'h0);
    bus(1'b0, 9'h048, 32'h0, rd, er);
    check("R2 pending tracks input after reset", 64'(rd), 64'h00004000);
    bus(1'b0, 9'h04C, 32'h0, rd, er);
    check("R9 masked word zero after reset", 64'(rd), 64'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule